// File: doc/BRIEF.md
# Masked Serial Address Recognizer

This block sits next to a 9-bit multiprocessor serial receiver. Each time the receiver completes a frame, it decides whether the receive interrupt should be set for that frame. When multiprocessor operation is on, the ninth received bit marks an address frame. The received byte is compared with a stored node address under a per-bit mask. Mask bits at 0 become don't-care positions. A mask of all zeros lets every address byte through, which is how a node listens to every station. A broadcast address can be stored in place of the node's own address.

The block is built for `NUM_PORTS` independent serial ports. Each port has its own address register, its own mask register and its own gating. The registers are loaded through a shared write-data bus with per-port write strobes. Each port has two outputs. The first is a one-clock interrupt-set pulse. The second is a match flag, which records whether the last completed frame was an address frame that matched.

Top module: `masked_addr_recognizer`

## Requirements
- R1: Synchronous reset clears both outputs of every port, and it clears every address register and every mask register. After reset, with the mask at zero, any address frame raises the interrupt.
- R2: In multiprocessor mode, for an address frame (ninth bit 1), each position whose mask bit is 1 must have a received data bit equal to the stored address bit. If any such position differs, no interrupt is raised.
- R3: In the comparison, a position whose mask bit is 0 is ignored. Flipping the received bit at that position does not change the outcome.
- R4: When every mask bit is 0, any address frame raises the interrupt and sets the match flag.
- R5: In multiprocessor mode, a data frame (ninth bit 0) raises no interrupt and clears the match flag.
- R6: With multiprocessor mode off, every completed frame raises the interrupt, whatever its ninth bit and data are.
- R7: The interrupt-set pulse is high for exactly the one clock after the cycle in which the frame-done strobe was high. It is never high at any other time.
- R8: On each frame-done strobe, the match flag is loaded with (ninth bit AND masked compare hit). Between strobes it holds its value.
- R9: Ports are independent. A frame, a register write or a mode setting on one port has no effect on another port's outputs.
- R10: A register write takes effect on the next clock. A frame that completes in the same cycle as a write is compared against the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wdata | input | DATA_W | Shared write data for the address and mask registers |
| cfg_addr_we | input | NUM_PORTS | Per-port strobe that loads the address register |
| cfg_mask_we | input | NUM_PORTS | Per-port strobe that loads the mask register |
| mp_en | input | NUM_PORTS | Per-port multiprocessor mode enable |
| frame_done | input | NUM_PORTS | Per-port frame-complete strobe, one clock |
| rx_data | input | NUM_PORTS x DATA_W | Received data byte per port |
| rx_bit9 | input | NUM_PORTS | Ninth received bit per port |
| irq_set | output | NUM_PORTS | One-clock receive-interrupt set pulse |
| match_flag | output | NUM_PORTS | Captured match result of the last frame |

## Verification
Several properties are checked on every clock by assertions:
- the interrupt pulse only ever follows a strobe;
- it always follows a strobe when multiprocessor mode is off;
- data frames in multiprocessor mode stay silent;
- the flag holds between strobes;
- for address frames, the interrupt agrees with the masked compare against the stored registers.

Other behaviours can only be shown by the bench's scenarios. These are: registers cleared by reset, don't-care positions under a partial mask, the ordering of a write against a frame in the same cycle, and isolation between ports. The bench shows them by comparing each port against a behavioural model on every clock.

// File: rtl/maddr_pkg.sv
package maddr_pkg;

  // Outcome class of a completed frame, used for gating
  typedef enum logic [1:0] {
    FR_PASS_ALL  = 2'd0,  // multiprocessor mode off
    FR_ADDR_HIT  = 2'd1,  // address frame, masked compare hit
    FR_ADDR_MISS = 2'd2,  // address frame, masked compare miss
    FR_DATA      = 2'd3   // data frame in multiprocessor mode
  } frame_class_e;

  function automatic frame_class_e classify(input logic mp, input logic b9, input logic hit);
    if (!mp)      return FR_PASS_ALL;
    else if (!b9) return FR_DATA;
    else if (hit) return FR_ADDR_HIT;
    else          return FR_ADDR_MISS;
  endfunction

endpackage

// File: rtl/maddr_cfg_regs.sv
module maddr_cfg_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              addr_we,
  input  logic              mask_we,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      if (addr_we) addr_q <= wdata;
      if (mask_we) mask_q <= wdata;
    end
  end

endmodule

// File: rtl/maddr_compare.sv
module maddr_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);

  logic [DATA_W-1:0] diff_bits;

  // A bit position mismatches only where the mask marks it as significant
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff_bits[b] = mask[b] & (data[b] ^ addr[b]);
  end

  assign hit = ~|diff_bits;

endmodule

// File: rtl/maddr_irq_gate.sv
module maddr_irq_gate
  import maddr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic mp,
  input  logic b9,
  input  logic hit,
  output logic irq_q,
  output logic flag_q
);

  frame_class_e cls;
  logic         irq_d;

  assign cls   = classify(mp, b9, hit);
  assign irq_d = done && (cls == FR_PASS_ALL || cls == FR_ADDR_HIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (done) flag_q <= b9 & hit;
    end
  end

endmodule

// File: rtl/masked_addr_recognizer.sv
module masked_addr_recognizer #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [DATA_W-1:0]                cfg_wdata,
  input  logic [NUM_PORTS-1:0]             cfg_addr_we,
  input  logic [NUM_PORTS-1:0]             cfg_mask_we,
  input  logic [NUM_PORTS-1:0]             mp_en,
  input  logic [NUM_PORTS-1:0]             frame_done,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
  input  logic [NUM_PORTS-1:0]             rx_bit9,
  output logic [NUM_PORTS-1:0]             irq_set,
  output logic [NUM_PORTS-1:0]             match_flag
);

  logic [NUM_PORTS-1:0][DATA_W-1:0] addr_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0] mask_q;
  logic [NUM_PORTS-1:0]             hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    maddr_cfg_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wdata   (cfg_wdata),
      .addr_we (cfg_addr_we[p]),
      .mask_we (cfg_mask_we[p]),
      .addr_q  (addr_q[p]),
      .mask_q  (mask_q[p])
    );

    maddr_compare #(.DATA_W(DATA_W)) u_cmp (
      .data (rx_data[p]),
      .addr (addr_q[p]),
      .mask (mask_q[p]),
      .hit  (hit[p])
    );

    maddr_irq_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .done   (frame_done[p]),
      .mp     (mp_en[p]),
      .b9     (rx_bit9[p]),
      .hit    (hit[p]),
      .irq_q  (irq_set[p]),
      .flag_q (match_flag[p])
    );
  end

endmodule

// File: rtl/maddr_recognizer_chk.sv
module maddr_recognizer_chk #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_PORTS-1:0]             mp_en,
  input logic [NUM_PORTS-1:0]             frame_done,
  input logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
  input logic [NUM_PORTS-1:0]             rx_bit9,
  input logic [NUM_PORTS-1:0][DATA_W-1:0] addr_q,
  input logic [NUM_PORTS-1:0][DATA_W-1:0] mask_q,
  input logic [NUM_PORTS-1:0]             irq_set,
  input logic [NUM_PORTS-1:0]             match_flag
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R7
    irq_after_done_chk: assert property (@(posedge clk) disable iff (rst)
      irq_set[p] |-> $past(frame_done[p]));

    // R6
    mp_off_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_done[p] && !mp_en[p]) |=> irq_set[p]);

    // R5
    data_frame_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_done[p] && mp_en[p] && !rx_bit9[p]) |=> (!irq_set[p] && !match_flag[p]));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !frame_done[p] |=> $stable(match_flag[p]));

    // R2
    addr_compare_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_done[p] && mp_en[p] && rx_bit9[p] && ((rx_data[p] ^ addr_q[p]) & mask_q[p]) != '0)
      |=> !irq_set[p]);

    // R4
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_done[p] && rx_bit9[p] && mask_q[p] == '0) |=> (irq_set[p] && match_flag[p]));
  end

endmodule

bind masked_addr_recognizer maddr_recognizer_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mp_en      (mp_en),
  .frame_done (frame_done),
  .rx_data    (rx_data),
  .rx_bit9    (rx_bit9),
  .addr_q     (addr_q),
  .mask_q     (mask_q),
  .irq_set    (irq_set),
  .match_flag (match_flag)
);

// File: tb/test_masked_addr_recognizer.sv
module test_masked_addr_recognizer;

  localparam int NP = 2;
  localparam int DW = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [DW-1:0]        cfg_wdata = '0;
  logic [NP-1:0]        cfg_addr_we = '0;
  logic [NP-1:0]        cfg_mask_we = '0;
  logic [NP-1:0]        mp_en = '0;
  logic [NP-1:0]        frame_done = '0;
  logic [NP-1:0][DW-1:0] rx_data = '0;
  logic [NP-1:0]        rx_bit9 = '0;
  logic [NP-1:0]        irq_set;
  logic [NP-1:0]        match_flag;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int    m_addr [NP];
  int    m_mask [NP];
  bit    m_irq  [NP];
  bit    m_flag [NP];
  string m_tag  [NP];

  always #5 clk = ~clk;

  masked_addr_recognizer #(.NUM_PORTS(NP), .DATA_W(DW)) i_masked_addr_recognizer (
    .clk(clk), .rst(rst), .cfg_wdata(cfg_wdata), .cfg_addr_we(cfg_addr_we),
    .cfg_mask_we(cfg_mask_we), .mp_en(mp_en), .frame_done(frame_done),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .irq_set(irq_set), .match_flag(match_flag)
  );

  always @(posedge clk) begin
    cycles++;
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        m_addr[p] = 0; m_mask[p] = 0; m_irq[p] = 0; m_flag[p] = 0; m_tag[p] = "R1";
      end else begin
        bit hitp;
        hitp = (((int'(rx_data[p]) ^ m_addr[p]) & m_mask[p]) == 0);
        m_irq[p] = frame_done[p] && (!mp_en[p] || (rx_bit9[p] && hitp));
        if (frame_done[p]) m_flag[p] = rx_bit9[p] && hitp;
        if (!frame_done[p])      m_tag[p] = "R7/R8";
        else if (!mp_en[p])      m_tag[p] = "R6";
        else if (!rx_bit9[p])    m_tag[p] = "R5";
        else if (m_mask[p] == 0) m_tag[p] = "R4";
        else                     m_tag[p] = "R2/R3";
        if (cfg_addr_we[p]) m_addr[p] = int'(cfg_wdata);
        if (cfg_mask_we[p]) m_mask[p] = int'(cfg_wdata);
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      for (int p = 0; p < NP; p++) begin
        tests++;
        if (irq_set[p] !== m_irq[p]) begin
          fails++;
          $display("FAIL %s port%0d cycle%0d irq_set actual=%0b expected=%0b", m_tag[p], p, cycles, irq_set[p], m_irq[p]);
        end
        tests++;
        if (match_flag[p] !== m_flag[p]) begin
          fails++;
          $display("FAIL %s port%0d cycle%0d match_flag actual=%0b expected=%0b", m_tag[p], p, cycles, match_flag[p], m_flag[p]);
        end
      end
    end
  end

  task automatic check(input string tag, input int p, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port%0d actual=%0b expected=%0b", tag, p, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [DW-1:0] a, input logic [DW-1:0] m);
    @(negedge clk);
    cfg_wdata = a; cfg_addr_we[p] = 1'b1;
    @(negedge clk);
    cfg_addr_we[p] = 1'b0; cfg_wdata = m; cfg_mask_we[p] = 1'b1;
    @(negedge clk);
    cfg_mask_we[p] = 1'b0;
  endtask

  // one frame on port p; checks the pulse and its end
  task automatic frame(input string tag, input int p, input logic [DW-1:0] d, input bit b9,
                       input bit mp, input bit exp_irq);
    @(negedge clk);
    mp_en[p] = mp; rx_data[p] = d; rx_bit9[p] = b9; frame_done[p] = 1'b1;
    @(negedge clk);
    frame_done[p] = 1'b0;
    check(tag, p, irq_set[p], exp_irq);
    @(negedge clk);
    check("R7", p, irq_set[p], 1'b0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin m_addr[p] = 0; m_mask[p] = 0; m_irq[p] = 0; m_flag[p] = 0; m_tag[p] = "R1"; end
    repeat (3) @(negedge clk);
    check("R1", 0, irq_set[0], 1'b0);
    check("R1", 0, match_flag[0], 1'b0);
    rst = 1'b0;
    // R1: cleared registers pass any address frame
    frame("R1", 0, 8'h5A, 1, 1, 1);
    check("R1", 0, match_flag[0], 1'b1);
    // R2: exact match and single-bit miss
    wr(0, 8'h3C, 8'hFF);
    frame("R2", 0, 8'h3C, 1, 1, 1);
    frame("R2", 0, 8'h3D, 1, 1, 0);
    check("R8", 0, match_flag[0], 1'b0);
    // R3: low nibble don't-care
    wr(0, 8'hA0, 8'hF0);
    frame("R3", 0, 8'hA7, 1, 1, 1);
    frame("R3", 0, 8'hAF, 1, 1, 1);
    frame("R2", 0, 8'hB0, 1, 1, 0);
    // R8: flag holds through idle cycles
    frame("R8", 0, 8'hA1, 1, 1, 1);
    repeat (4) @(negedge clk);
    check("R8", 0, match_flag[0], 1'b1);
    // R5: data frame silent, clears flag
    frame("R5", 0, 8'hA0, 0, 1, 0);
    check("R5", 0, match_flag[0], 1'b0);
    // R6: mode off passes everything
    frame("R6", 0, 8'h00, 0, 0, 1);
    frame("R6", 0, 8'hFF, 1, 0, 1);
    // R4: zero mask
    wr(0, 8'h77, 8'h00);
    frame("R4", 0, 8'h11, 1, 1, 1);
    check("R4", 0, match_flag[0], 1'b1);
    // R9: port 1 programmed apart; frame on port 0 leaves port 1 quiet
    wr(1, 8'h42, 8'hFF);
    wr(0, 8'h10, 8'hFF);
    frame("R9", 0, 8'h42, 1, 1, 0);
    check("R9", 1, irq_set[1], 1'b0);
    check("R9", 1, match_flag[1], 1'b0);
    frame("R9", 1, 8'h42, 1, 1, 1);
    check("R9", 0, match_flag[0], 1'b0);
    // R10: write and frame together; old address 0x42 is used
    @(negedge clk);
    cfg_wdata = 8'h99; cfg_addr_we[1] = 1'b1;
    rx_data[1] = 8'h42; rx_bit9[1] = 1'b1; mp_en[1] = 1'b1; frame_done[1] = 1'b1;
    @(negedge clk);
    cfg_addr_we[1] = 1'b0; frame_done[1] = 1'b0;
    check("R10", 1, irq_set[1], 1'b1);
    frame("R10", 1, 8'h99, 1, 1, 1);
    // mixed traffic, model-compared every clock
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfg_wdata   = DW'($urandom);
      cfg_addr_we = NP'(($urandom % 8 == 0) ? $urandom : 0);
      cfg_mask_we = NP'(($urandom % 8 == 0) ? $urandom : 0);
      mp_en       = NP'($urandom | $urandom);
      frame_done  = NP'($urandom);
      rx_bit9     = NP'($urandom);
      for (int p = 0; p < NP; p++) rx_data[p] = DW'(($urandom % 2) ? m_addr[p] ^ ($urandom & ~m_mask[p]) : $urandom);
    end
    @(negedge clk);
    cfg_addr_we = '0; cfg_mask_we = '0; frame_done = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule